// File: doc/BRIEF.md
# Multi-Rail Power-Good Supervisor

This block decides when a group of regulator rails may be declared healthy. For every rail it receives an enable bit and two raw comparator flags: one for under-voltage and one for over-voltage. It qualifies these flags with deglitch timers. The timer lengths depend on a strict/relaxed mode bit. A rail is ignored while it is disabled, and also during a start-up blanking window that begins when the rail is enabled.

From the qualified faults it drives an active-high power-good output and a one-cycle shutdown request to the power-down sequencer. Power-good is released a programmable number of ticks after the sequencer reports that power-up is complete. A qualified fault removes it at once. It is forced low while power-down is running or while the system is suspended.

All timing counts ticks from an internal clock-enable divider. The divider period is a parameter. At the default of 1250 cycles and a 125 MHz clock, one tick is 10 µs. The deglitch and blanking limits are parameters given in ticks. The power-good delay input is also given directly in ticks.

Top module: `pg_supervisor`

## Requirements
- R1: After reset, `pg_o` is low and `fault_req_o` is low.
- R2: With `mode_strict_i`=0, an enabled and armed rail's under-voltage flag becomes a fault once it has been high for UV_RELAX_TK consecutive ticks. In this mode the over-voltage flag is ignored, however long it stays high.
- R3: With `mode_strict_i`=1, under-voltage becomes a fault after UV_STRICT_TK consecutive ticks, and over-voltage becomes a fault after OV_SET_TK consecutive ticks.
- R4: A pending count restarts from zero in any cycle in which the raw flag returns to its good level. A qualified fault clears only after the flag has been good for UV_REC_TK ticks (under-voltage) or OV_REC_TK ticks (over-voltage).
- R5: A disabled rail never produces a fault. After a rail's enable bit is set, its flags are ignored for BLANK_TK ticks.
- R6: A one-cycle `seq_done_i` pulse with `pg_delay_i`=D>0 raises `pg_o` on the D-th tick after the pulse, provided no fault is present. With D=0, `pg_o` rises in the cycle after the pulse.
- R7: When a fault qualifies, `pg_o` drops in the same cycle and `fault_req_o` pulses for one cycle. `pg_o` then stays low until the next `seq_done_i`, even if the fault clears.
- R8: Clearing the enable of one rail while others stay enabled leaves `pg_o` unchanged. Clearing the last enable drives `pg_o` low.
- R9: `pg_o` is low while `suspend_i` is high, and it returns when suspend ends. `pg_o` is low while `pd_active_i` is high, and a power-down cancels the release, so `pg_o` stays low afterwards until the next `seq_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_strict_i | input | 1 | 1: check under- and over-voltage with short limits; 0: check under-voltage only |
| rail_en_i | input | N_RAILS | Per-rail enable |
| uv_raw_i | input | N_RAILS | Raw under-voltage comparator flags, high = below threshold |
| ov_raw_i | input | N_RAILS | Raw over-voltage comparator flags, high = above threshold |
| seq_done_i | input | 1 | One-cycle strobe: power-up sequence finished |
| pd_active_i | input | 1 | Power-down sequencer running |
| suspend_i | input | 1 | System in suspend state |
| pg_delay_i | input | DLY_W | Power-good release delay in ticks, sampled with `seq_done_i` |
| pg_o | output | 1 | Power-good, high = all monitored rails good |
| fault_req_o | output | 1 | One-cycle shutdown request to the power-down sequencer |

## Verification
The hardest state to reach is a rail whose fault has qualified but whose recovery count is still running. It can only be observed indirectly, through what happens at the next sequencer-done strobe. The bench clears an over-voltage flag and issues a zero-delay strobe one tick short of the recovery limit, then expects a fresh shutdown request with power-good held low. It then repeats the strobe after the limit and expects power-good to rise. Every deglitch and blanking boundary is approached from both sides by holding a flag for whole tick multiples. This makes the tick count seen by the design exact, whatever the phase of the divider.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic {
    MODE_RELAXED = 1'b0,
    MODE_STRICT  = 1'b1
  } pgs_mode_e;

  function automatic int pgs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pgs_tick_gen.sv
module pgs_tick_gen #(
  parameter int TICK_CYC = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == TW'(TICK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/pgs_deglitch.sv
module pgs_deglitch #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          raw_i,
  input  logic [CW-1:0] set_lim_i,
  input  logic [CW-1:0] clr_lim_i,
  output logic          flag_o
);
  logic          flag_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  // count toward the opposite state; limit depends on direction
  assign lim    = flag_q ? clr_lim_i : set_lim_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (raw_i == flag_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if ((cnt_q + CW'(1)) >= lim) begin
        flag_q <= ~flag_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_set_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(raw_i && tick_i && !clr_i));

  assert_clear_needs_good_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag_o) && !$past(clr_i)) |-> $past(!raw_i && tick_i));
endmodule

// File: rtl/pgs_rail_mon.sv
module pgs_rail_mon
  import pgs_pkg::*;
#(
  parameter int CW           = 8,
  parameter int BW           = 9,
  parameter int UV_RELAX_TK  = 100,
  parameter int UV_STRICT_TK = 5,
  parameter int UV_REC_TK    = 1,
  parameter int OV_SET_TK    = 100,
  parameter int OV_REC_TK    = 5,
  parameter int BLANK_TK     = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic strict_i,
  input  logic uv_i,
  input  logic ov_i,
  output logic fault_o
);
  pgs_mode_e     mode;
  logic [BW-1:0] blank_cnt_q;
  logic          armed_q;
  logic          active;
  logic [CW-1:0] uv_set_lim;
  logic          uv_flag;
  logic          ov_flag;

  assign mode = pgs_mode_e'(strict_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_cnt_q <= '0;
      armed_q     <= 1'b0;
    end else if (!en_i) begin
      blank_cnt_q <= '0;
      armed_q     <= 1'b0;
    end else if (!armed_q && tick_i) begin
      if ((blank_cnt_q + BW'(1)) >= BW'(BLANK_TK)) armed_q <= 1'b1;
      else blank_cnt_q <= blank_cnt_q + BW'(1);
    end
  end

  assign active     = en_i && armed_q;
  assign uv_set_lim = (mode == MODE_STRICT) ? CW'(UV_STRICT_TK) : CW'(UV_RELAX_TK);

  pgs_deglitch #(.CW(CW)) u_uv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (!active),
    .raw_i     (uv_i),
    .set_lim_i (uv_set_lim),
    .clr_lim_i (CW'(UV_REC_TK)),
    .flag_o    (uv_flag)
  );

  pgs_deglitch #(.CW(CW)) u_ov (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (!active || (mode != MODE_STRICT)),
    .raw_i     (ov_i),
    .set_lim_i (CW'(OV_SET_TK)),
    .clr_lim_i (CW'(OV_REC_TK)),
    .flag_o    (ov_flag)
  );

  assign fault_o = uv_flag || ov_flag;

  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fault_o);

  assert_relaxed_no_ov_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strict_i |=> !ov_flag);
endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor
  import pgs_pkg::*;
#(
  parameter int N_RAILS      = 5,
  parameter int TICK_CYC     = 1250,
  parameter int UV_RELAX_TK  = 100,
  parameter int UV_STRICT_TK = 5,
  parameter int UV_REC_TK    = 1,
  parameter int OV_SET_TK    = 100,
  parameter int OV_REC_TK    = 5,
  parameter int BLANK_TK     = 500,
  parameter int DLY_W        = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_strict_i,
  input  logic [N_RAILS-1:0] rail_en_i,
  input  logic [N_RAILS-1:0] uv_raw_i,
  input  logic [N_RAILS-1:0] ov_raw_i,
  input  logic               seq_done_i,
  input  logic               pd_active_i,
  input  logic               suspend_i,
  input  logic [DLY_W-1:0]   pg_delay_i,
  output logic               pg_o,
  output logic               fault_req_o
);
  localparam int LIM_MAX = pgs_max(pgs_max(pgs_max(UV_RELAX_TK, UV_STRICT_TK),
                                           pgs_max(UV_REC_TK, OV_SET_TK)), OV_REC_TK);
  localparam int CW = $clog2(LIM_MAX + 1);
  localparam int BW = $clog2(BLANK_TK + 1);

  logic               tick;
  logic [N_RAILS-1:0] rail_fault;
  logic               any_fault;
  logic               any_en;
  logic               fault_lat_q;
  logic               pg_rel_q;
  logic               dly_pend_q;
  logic [DLY_W-1:0]   dly_cnt_q;

  pgs_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    pgs_rail_mon #(
      .CW           (CW),
      .BW           (BW),
      .UV_RELAX_TK  (UV_RELAX_TK),
      .UV_STRICT_TK (UV_STRICT_TK),
      .UV_REC_TK    (UV_REC_TK),
      .OV_SET_TK    (OV_SET_TK),
      .OV_REC_TK    (OV_REC_TK),
      .BLANK_TK     (BLANK_TK)
    ) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .en_i     (rail_en_i[g]),
      .strict_i (mode_strict_i),
      .uv_i     (uv_raw_i[g]),
      .ov_i     (ov_raw_i[g]),
      .fault_o  (rail_fault[g])
    );
  end

  assign any_fault = |rail_fault;
  assign any_en    = |rail_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_lat_q <= 1'b0;
      pg_rel_q    <= 1'b0;
      dly_pend_q  <= 1'b0;
      dly_cnt_q   <= '0;
    end else if (seq_done_i) begin
      fault_lat_q <= 1'b0;
      if (pg_delay_i == '0) begin
        pg_rel_q   <= !any_fault;
        dly_pend_q <= 1'b0;
      end else begin
        pg_rel_q   <= 1'b0;
        dly_pend_q <= 1'b1;
        dly_cnt_q  <= pg_delay_i;
      end
    end else begin
      if (any_fault) fault_lat_q <= 1'b1;
      if (any_fault || pd_active_i || !any_en) begin
        pg_rel_q   <= 1'b0;
        dly_pend_q <= 1'b0;
      end else if (dly_pend_q && tick) begin
        if (dly_cnt_q == DLY_W'(1)) begin
          pg_rel_q   <= 1'b1;
          dly_pend_q <= 1'b0;
        end else begin
          dly_cnt_q <= dly_cnt_q - DLY_W'(1);
        end
      end
    end
  end

  // release path is delayed; fault and override paths are not
  assign pg_o = pg_rel_q && !fault_lat_q && !any_fault && !pd_active_i && !suspend_i && any_en;
  assign fault_req_o = any_fault && !fault_lat_q;

  assert_req_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_o && !seq_done_i) |=> !fault_req_o);

  assert_latched_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_o && !seq_done_i) |=> !pg_o);

  assert_rise_after_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_rel_q) |-> $past(seq_done_i || (dly_pend_q && tick)));

  assert_pd_cancels_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_active_i && !seq_done_i) |=> !pg_rel_q);
endmodule

// File: tb/pg_supervisor_tb.sv
module pg_supervisor_tb;
  localparam int N   = 5;
  localparam int TC  = 4;
  localparam int UVR = 20;
  localparam int UVS = 5;
  localparam int UVC = 1;
  localparam int OVS = 20;
  localparam int OVC = 5;
  localparam int BL  = 50;
  localparam int DW  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strict = 1'b0;
  logic [N-1:0]  en = '0;
  logic [N-1:0]  uv = '0;
  logic [N-1:0]  ov = '0;
  logic          done = 1'b0;
  logic          pd = 1'b0;
  logic          susp = 1'b0;
  logic [DW-1:0] dly = '0;
  logic          pg;
  logic          req;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pg_supervisor #(
    .N_RAILS(N), .TICK_CYC(TC), .UV_RELAX_TK(UVR), .UV_STRICT_TK(UVS),
    .UV_REC_TK(UVC), .OV_SET_TK(OVS), .OV_REC_TK(OVC), .BLANK_TK(BL), .DLY_W(DW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_strict_i(strict), .rail_en_i(en),
    .uv_raw_i(uv), .ov_raw_i(ov), .seq_done_i(done), .pd_active_i(pd),
    .suspend_i(susp), .pg_delay_i(dly), .pg_o(pg), .fault_req_o(req)
  );

  always @(negedge clk) if (rst_n && req) req_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(input int d);
    dly  = DW'(d);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic rearm();
    uv = '0;
    ov = '0;
    hold((OVC + 2) * TC);
    pulse_done(0);
    check("R6 zero-delay release", pg, 1);
  endtask

  task automatic t_reset();
    hold(3);
    check("R1 pg after reset", pg, 0);
    check("R1 req after reset", req, 0);
    rst_n = 1'b1;
    hold(2);
    check("R1 pg idle", pg, 0);
  endtask

  task automatic t_power_up();
    en = '1;
    hold((BL + 2) * TC);
    check("R6 pg before strobe", pg, 0);
    pulse_done(6);
    hold(5 * TC);
    check("R6 pg one tick before delay", pg, 0);
    hold(TC);
    check("R6 pg at delay", pg, 1);
  endtask

  task automatic t_relaxed();
    int base;
    ov[1] = 1'b1;
    hold((OVS + 3) * TC);
    check("R2 ov ignored relaxed", pg, 1);
    ov[1] = 1'b0;
    uv[2] = 1'b1;
    hold((UVR - 1) * TC);
    uv[2] = 1'b0;
    @(negedge clk);
    check("R2 uv below limit", pg, 1);
    // glitch restarts the count
    uv[2] = 1'b1;
    hold((UVR - 1) * TC);
    uv[2] = 1'b0;
    @(negedge clk);
    uv[2] = 1'b1;
    hold((UVR - 1) * TC);
    uv[2] = 1'b0;
    @(negedge clk);
    check("R4 count restarts", pg, 1);
    base = req_cnt;
    uv[2] = 1'b1;
    hold((UVR + 1) * TC);
    check("R2 uv above limit", pg, 0);
    check("R7 one request", req_cnt - base, 1);
    uv[2] = 1'b0;
    hold((UVC + 3) * TC);
    check("R7 latched low", pg, 0);
    rearm();
  endtask

  task automatic t_strict();
    int base;
    strict = 1'b1;
    uv[0] = 1'b1;
    hold((UVS - 1) * TC);
    uv[0] = 1'b0;
    @(negedge clk);
    check("R3 uv below strict limit", pg, 1);
    uv[0] = 1'b1;
    hold((UVS + 1) * TC);
    check("R3 uv above strict limit", pg, 0);
    rearm();
    ov[4] = 1'b1;
    hold((OVS - 1) * TC);
    ov[4] = 1'b0;
    @(negedge clk);
    check("R3 ov below limit", pg, 1);
    base = req_cnt;
    ov[4] = 1'b1;
    hold((OVS + 1) * TC);
    check("R3 ov above limit", pg, 0);
    check("R7 request on ov", req_cnt - base, 1);
    // recovery not yet complete at the strobe
    ov[4] = 1'b0;
    hold((OVC - 1) * TC - 1);
    base = req_cnt;
    pulse_done(0);
    @(negedge clk);
    check("R4 ov recovery too short", pg, 0);
    check("R4 fresh request", req_cnt - base, 1);
    hold((OVC + 1) * TC);
    pulse_done(0);
    check("R4 ov recovered", pg, 1);
    strict = 1'b0;
  endtask

  task automatic t_enables();
    en[3] = 1'b0;
    hold(2);
    check("R8 one rail off", pg, 1);
    uv[3] = 1'b1;
    hold((UVR + 3) * TC);
    check("R5 disabled rail ignored", pg, 1);
    en[3] = 1'b1;
    hold((BL - 2) * TC);
    check("R5 blanking window", pg, 1);
    hold((UVR + 4) * TC);
    check("R5 monitored after blanking", pg, 0);
    rearm();
    for (int i = 0; i < N - 1; i++) begin
      en[i] = 1'b0;
      hold(2);
      check("R8 partial disable", pg, 1);
    end
    en[N-1] = 1'b0;
    hold(1);
    check("R8 last rail off", pg, 0);
    en = '1;
    hold((BL + 2) * TC);
    pulse_done(0);
    check("R8 restart", pg, 1);
  endtask

  task automatic t_override();
    susp = 1'b1;
    hold(1);
    check("R9 suspend low", pg, 0);
    susp = 1'b0;
    hold(1);
    check("R9 suspend exit", pg, 1);
    pd = 1'b1;
    hold(1);
    check("R9 power-down low", pg, 0);
    pd = 1'b0;
    hold(3);
    check("R9 release cancelled", pg, 0);
    pulse_done(2);
    hold(2 * TC);
    check("R9 new release", pg, 1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_relaxed();
    t_strict();
    t_enables();
    t_override();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule